// File: doc/BRIEF.md
# Clock Reference Selection Controller

This block is the control state machine of a network timing unit. It decides whether the local oscillator runs on its own (free run) or follows one of two external trunk references. One reference is the primary and the other is a backup. It reads a configured flag, an enabled flag and a local-alarm flag for each reference, a controller enable, and three single-cycle operator commands. It drives the selected source, a 2-bit state code, a tracking flag and a one-cycle pulse on every change of source. The phase-locked loop, the frequency measurement and the clock fan-out are outside this block.

A prescaler divides the clock into ticks, one every `PRESCALE` cycles, and both programmable periods count these ticks. When the controller is enabled it stays in a mandatory free-run hold for `hold_ticks` ticks. It then selects a reference automatically. A raw alarm is filtered in both directions for `dbc_ticks` ticks, so a reference is dropped only after a persistent alarm and is taken back only after it has been clear for the same period.

The states are OFF (disabled), HOLD (startup free run), FREE (automatic free run), FORCE (operator free run), PRI (tracking the primary) and SEC (tracking the secondary). The transitions are:
- any state goes to OFF when the enable is low;
- OFF goes to HOLD;
- HOLD goes to the automatic pick when the hold period ends;
- FREE, PRI and SEC move among one another by the automatic pick, and go to FORCE on a free-run command;
- FORCE leaves only on a track command, to the automatic pick.

Top module: `clkref_sel`

## Requirements
- R1: While `ctl_en` is low, and after reset, `st_code`=00 and `sel_src`=00. One clock edge after `ctl_en` falls, the block is back in this state.
- R2: After `ctl_en` rises, the block enters the hold state (`st_code`=00) at the next edge. It stays there until `hold_ticks` ticks (one tick every `PRESCALE` cycles) have been counted. With `hold_ticks`=0 it leaves at the second edge. Operator commands given during the hold have no effect.
- R3: A reference is usable when it is configured, enabled and its filtered alarm is clear. In automatic selection a usable primary is chosen (`sel_src`=01, `st_code`=11).
- R4: When the primary is unusable and the secondary is usable, the secondary is chosen (`sel_src`=10, `st_code`=11).
- R5: When neither reference is usable, the block free-runs automatically (`st_code`=01, `sel_src`=00). A disable takes effect at the next edge.
- R6: A raw alarm sets the filtered alarm only after it is seen high at `dbc_ticks` consecutive ticks, with no clear cycle in between. A value of 0 behaves like 1. Shorter alarm pulses have no effect on the selection.
- R7: A cleared alarm clears the filtered alarm only after `dbc_ticks` consecutive clear ticks. The block then returns to the primary automatically.
- R8: A secondary that is not configured (`sec_cfg`=0) is never selected.
- R9: `cmd_frun` moves the block to forced free run (`st_code`=10, `sel_src`=00) at the next edge. It stays there, whatever the references do, until `cmd_pri` or `cmd_sec`.
- R10: `cmd_sec` makes the secondary preferred while it is usable, even over a usable primary. `cmd_pri` restores preference for the primary. Commands given in the same cycle rank `cmd_frun`, then `cmd_sec`, then `cmd_pri`.
- R11: `sw_evt` is high for exactly the one cycle in which `sel_src` takes a new value, and at no other time.
- R12: `tracking` is 1 exactly when `sel_src` is non-zero. `sel_src` never has both bits set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_en | input | 1 | Controller enable |
| pri_cfg | input | 1 | Primary reference configured |
| pri_en | input | 1 | Primary reference enabled |
| pri_alm | input | 1 | Primary raw local alarm |
| sec_cfg | input | 1 | Secondary reference configured |
| sec_en | input | 1 | Secondary reference enabled |
| sec_alm | input | 1 | Secondary raw local alarm |
| cmd_pri | input | 1 | Operator: track with primary preferred |
| cmd_sec | input | 1 | Operator: switch to secondary |
| cmd_frun | input | 1 | Operator: force free run |
| hold_ticks | input | HOLD_W | Startup hold length in ticks |
| dbc_ticks | input | DBC_W | Alarm filter length in ticks |
| sel_src | output | 2 | 00 none, 01 primary, 10 secondary |
| st_code | output | 2 | 00 off/hold, 01 free run, 10 forced free run, 11 tracking |
| tracking | output | 1 | Tracking a reference |
| sw_evt | output | 1 | One-cycle pulse on a source change |

## Verification
Two functions can act in the same cycle. One is an operator command. The other is an automatic change, which is either a reference loss caused by a disable or by a filter expiring, or a primary recovery. The bench provokes this directly with a free-run command issued together with a track command in forced mode. It also runs a long random phase with dense command pulses and alarm toggles, so that commands often land on the edge where a filter completes. A reference model built from the requirements is compared against the outputs in every cycle. The model gives command ranking and preference priority over the automatic pick.

// File: rtl/clkref_pkg.sv
package clkref_pkg;

    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,
        ST_HOLD  = 3'd1,
        ST_FREE  = 3'd2,
        ST_FORCE = 3'd3,
        ST_PRI   = 3'd4,
        ST_SEC   = 3'd5
    } sel_state_t;

    localparam logic [1:0] SRC_NONE = 2'b00;
    localparam logic [1:0] SRC_PRI  = 2'b01;
    localparam logic [1:0] SRC_SEC  = 2'b10;

    localparam logic [1:0] CODE_HOLDOFF = 2'b00;
    localparam logic [1:0] CODE_FREE    = 2'b01;
    localparam logic [1:0] CODE_FORCED  = 2'b10;
    localparam logic [1:0] CODE_TRACK   = 2'b11;

    // automatic choice between the two references
    function automatic sel_state_t pick_ref(input logic up, input logic us, input logic pref_sec);
        if (pref_sec)
            return us ? ST_SEC : (up ? ST_PRI : ST_FREE);
        return up ? ST_PRI : (us ? ST_SEC : ST_FREE);
    endfunction

endpackage

// File: rtl/clkref_tick.sv
module clkref_tick #(
    parameter int PRESCALE = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

    logic [PW-1:0] pcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            pcnt <= '0;
        else if (pcnt == LAST) pcnt <= '0;
        else                   pcnt <= pcnt + 1'b1;
    end

    assign tick = (pcnt == LAST);
endmodule

// File: rtl/clkref_dbnc.sv
module clkref_dbnc #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          raw,
    input  logic [CW-1:0] limit,
    output logic          filt
);
    logic [CW-1:0] cnt;
    logic [CW:0]   cnt_inc;

    always_comb cnt_inc = {1'b0, cnt} + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filt <= 1'b0;
            cnt  <= '0;
        end else if (raw == filt) begin
            cnt <= '0;
        end else if (tick) begin
            if (cnt_inc >= {1'b0, limit}) begin
                filt <= raw;
                cnt  <= '0;
            end else begin
                cnt <= cnt_inc[CW-1:0];
            end
        end
    end

    AST_FILT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (filt != $past(filt)) |-> $past(tick)); // R6
    AST_FILT_FOLLOWS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        (filt != $past(filt)) |-> ($past(raw) == filt)); // R7
endmodule

// File: rtl/clkref_hold.sv
module clkref_hold #(
    parameter int HW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          run,
    input  logic [HW-1:0] limit,
    output logic          done
);
    logic [HW-1:0] hcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              hcnt <= '0;
        else if (!run)           hcnt <= '0;
        else if (tick && !done)  hcnt <= hcnt + 1'b1;
    end

    assign done = run && (hcnt >= limit);

    AST_HOLD_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(run)) |-> (hcnt == '0)); // R2
endmodule

// File: rtl/clkref_sel.sv
module clkref_sel
    import clkref_pkg::*;
#(
    parameter int PRESCALE = 4,
    parameter int HOLD_W   = 8,
    parameter int DBC_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_en,
    input  logic              pri_cfg,
    input  logic              pri_en,
    input  logic              pri_alm,
    input  logic              sec_cfg,
    input  logic              sec_en,
    input  logic              sec_alm,
    input  logic              cmd_pri,
    input  logic              cmd_sec,
    input  logic              cmd_frun,
    input  logic [HOLD_W-1:0] hold_ticks,
    input  logic [DBC_W-1:0]  dbc_ticks,
    output logic [1:0]        sel_src,
    output logic [1:0]        st_code,
    output logic              tracking,
    output logic              sw_evt
);
    localparam int NREF = 2;

    sel_state_t      state, nxt;
    logic            pref_sec, pref_nxt;
    logic            tick, hold_done;
    logic [NREF-1:0] raw_alm, filt_alm;
    logic            up, us;
    logic [1:0]      sel_q;

    clkref_tick #(.PRESCALE(PRESCALE)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    assign raw_alm = {sec_alm, pri_alm};

    for (genvar g = 0; g < NREF; g++) begin : g_dbnc
        clkref_dbnc #(.CW(DBC_W)) u_dbnc (
            .clk(clk), .rst_n(rst_n), .tick(tick),
            .raw(raw_alm[g]), .limit(dbc_ticks), .filt(filt_alm[g])
        );
    end

    clkref_hold #(.HW(HOLD_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .run(state == ST_HOLD), .limit(hold_ticks), .done(hold_done)
    );

    assign up = pri_cfg && pri_en && !filt_alm[0];
    assign us = sec_cfg && sec_en && !filt_alm[1];

    always_comb begin
        nxt      = state;
        pref_nxt = pref_sec;
        if (!ctl_en) begin
            nxt      = ST_OFF;
            pref_nxt = 1'b0;
        end else begin
            unique case (state)
                ST_OFF:  nxt = ST_HOLD;
                ST_HOLD: if (hold_done) nxt = pick_ref(up, us, 1'b0);
                ST_FORCE: begin
                    if (cmd_frun) begin
                        nxt = ST_FORCE;
                    end else if (cmd_sec) begin
                        pref_nxt = 1'b1;
                        nxt      = pick_ref(up, us, 1'b1);
                    end else if (cmd_pri) begin
                        pref_nxt = 1'b0;
                        nxt      = pick_ref(up, us, 1'b0);
                    end
                end
                ST_FREE, ST_PRI, ST_SEC: begin
                    if (cmd_frun) begin
                        nxt = ST_FORCE;
                    end else if (cmd_sec) begin
                        pref_nxt = 1'b1;
                        nxt      = pick_ref(up, us, 1'b1);
                    end else if (cmd_pri) begin
                        pref_nxt = 1'b0;
                        nxt      = pick_ref(up, us, 1'b0);
                    end else begin
                        nxt = pick_ref(up, us, pref_sec);
                    end
                end
                default: nxt = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_OFF;
            pref_sec <= 1'b0;
            sel_q    <= SRC_NONE;
        end else begin
            state    <= nxt;
            pref_sec <= pref_nxt;
            sel_q    <= sel_src;
        end
    end

    always_comb begin
        unique case (state)
            ST_PRI:   begin sel_src = SRC_PRI;  st_code = CODE_TRACK;   end
            ST_SEC:   begin sel_src = SRC_SEC;  st_code = CODE_TRACK;   end
            ST_FREE:  begin sel_src = SRC_NONE; st_code = CODE_FREE;    end
            ST_FORCE: begin sel_src = SRC_NONE; st_code = CODE_FORCED;  end
            default:  begin sel_src = SRC_NONE; st_code = CODE_HOLDOFF; end
        endcase
        tracking = (sel_src != SRC_NONE);
        sw_evt   = (sel_src != sel_q);
    end

    AST_OFF_WHEN_DIS: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_en |=> (st_code == CODE_HOLDOFF && sel_src == SRC_NONE)); // R1
    AST_HOLD_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF && ctl_en) |=> (state == ST_HOLD)); // R2
    AST_PRI_USABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_src == SRC_PRI) |-> $past(pri_cfg && pri_en)); // R3
    AST_NO_SEC_UNCFG: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_src == SRC_SEC) |-> $past(sec_cfg)); // R8
    AST_FORCE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FORCE && ctl_en && !cmd_pri && !cmd_sec) |=> (state == ST_FORCE)); // R9
    AST_EVT_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        sw_evt |-> (sel_src != $past(sel_src))); // R11
    AST_SEL_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_src)); // R12
endmodule

// File: tb/sim_clkref_sel.sv
module sim_clkref_sel;
    localparam int CLK_P = 10;
    localparam int PRESC = 4;
    localparam int HW    = 8;
    localparam int DW    = 4;

    localparam int M_OFF = 0, M_HOLD = 1, M_FREE = 2, M_FORCE = 3, M_PRI = 4, M_SEC = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_en = 0, pri_cfg = 0, pri_en = 0, pri_alm = 0;
    logic sec_cfg = 0, sec_en = 0, sec_alm = 0;
    logic cmd_pri = 0, cmd_sec = 0, cmd_frun = 0;
    logic [HW-1:0] hold_ticks = 8'd3;
    logic [DW-1:0] dbc_ticks  = 4'd2;
    logic [1:0] sel_src, st_code;
    logic tracking, sw_evt;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #(CLK_P/2) clk = ~clk;

    clkref_sel #(.PRESCALE(PRESC), .HOLD_W(HW), .DBC_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en),
        .pri_cfg(pri_cfg), .pri_en(pri_en), .pri_alm(pri_alm),
        .sec_cfg(sec_cfg), .sec_en(sec_en), .sec_alm(sec_alm),
        .cmd_pri(cmd_pri), .cmd_sec(cmd_sec), .cmd_frun(cmd_frun),
        .hold_ticks(hold_ticks), .dbc_ticks(dbc_ticks),
        .sel_src(sel_src), .st_code(st_code), .tracking(tracking), .sw_evt(sw_evt)
    );

    // ---------------- reference model from the requirements ----------------
    int m_st, m_pc, m_hc, m_cp, m_cs, m_selq;
    bit m_fp, m_fs, m_pref;

    function automatic int m_pick(bit up, bit us, bit pref);
        if (pref) return us ? M_SEC : (up ? M_PRI : M_FREE);
        return up ? M_PRI : (us ? M_SEC : M_FREE);
    endfunction

    function automatic int exp_sel(int st);
        if (st == M_PRI) return 1;
        if (st == M_SEC) return 2;
        return 0;
    endfunction

    function automatic int exp_code(int st);
        if (st == M_FREE)  return 1;
        if (st == M_FORCE) return 2;
        if (st == M_PRI || st == M_SEC) return 3;
        return 0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        bit mtick, up, us, hdone, pref;
        int nst;
        if (!rst_n) begin
            m_st <= M_OFF; m_pc <= 0; m_hc <= 0; m_cp <= 0; m_cs <= 0;
            m_fp <= 0; m_fs <= 0; m_pref <= 0; m_selq <= 0;
        end else begin
            mtick = (m_pc == PRESC - 1);
            up    = pri_cfg && pri_en && !m_fp;
            us    = sec_cfg && sec_en && !m_fs;
            hdone = (m_st == M_HOLD) && (m_hc >= int'(hold_ticks));
            nst   = m_st;
            pref  = m_pref;
            if (!ctl_en) begin
                nst = M_OFF; pref = 0;
            end else if (m_st == M_OFF) begin
                nst = M_HOLD;
            end else if (m_st == M_HOLD) begin
                if (hdone) nst = m_pick(up, us, 0);
            end else if (cmd_frun) begin
                nst = M_FORCE;
            end else if (cmd_sec) begin
                pref = 1; nst = m_pick(up, us, 1);
            end else if (cmd_pri) begin
                pref = 0; nst = m_pick(up, us, 0);
            end else if (m_st != M_FORCE) begin
                nst = m_pick(up, us, m_pref);
            end
            m_st   <= nst;
            m_pref <= pref;
            m_selq <= exp_sel(m_st);
            m_pc   <= mtick ? 0 : m_pc + 1;
            if (m_st != M_HOLD) m_hc <= 0;
            else if (mtick && !hdone) m_hc <= m_hc + 1;
            if (pri_alm == m_fp) m_cp <= 0;
            else if (mtick) begin
                if (m_cp + 1 >= int'(dbc_ticks)) begin m_fp <= pri_alm; m_cp <= 0; end
                else m_cp <= m_cp + 1;
            end
            if (sec_alm == m_fs) m_cs <= 0;
            else if (mtick) begin
                if (m_cs + 1 >= int'(dbc_ticks)) begin m_fs <= sec_alm; m_cs <= 0; end
                else m_cs <= m_cs + 1;
            end
        end
    end

    // ---------------- checking helpers ----------------
    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_change(input int lim);
        logic [1:0] last;
        last = sel_src;
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            if (sel_src != last) break;
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_c10c));
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        chk("R1 reset sel", sel_src, 0);
        chk("R1 reset code", st_code, 0);
        chk("R12 reset trk", tracking, 0);
        chk("R11 reset evt", sw_evt, 0);

        // R2: hold, with a command ignored inside it
        pri_cfg = 1; pri_en = 1; sec_cfg = 1; sec_en = 1; ctl_en = 1;
        cyc(1); cmd_frun = 1; cyc(1); cmd_frun = 0;
        cyc(6);
        chk("R2 still holding", st_code, 0);
        cyc(16);
        chk("R2 hold over, tracking", st_code, 3);
        chk("R3 primary chosen", sel_src, 1);

        // R6: short alarm pulse is ignored
        pri_alm = 1; cyc(3); pri_alm = 0; cyc(10);
        chk("R6 glitch ignored", sel_src, 1);

        // R4 / R11: persistent alarm moves to secondary
        pri_alm = 1;
        wait_change(40);
        chk("R4 fallback to secondary", sel_src, 2);
        chk("R11 pulse on change", sw_evt, 1);
        cyc(1);
        chk("R11 pulse one cycle", sw_evt, 0);

        // R7: recovery is filtered then returns to primary
        pri_alm = 0; cyc(2);
        chk("R7 recovery still filtered", sel_src, 2);
        wait_change(40);
        chk("R7 back to primary", sel_src, 1);

        // R5: both disabled
        pri_en = 0; sec_en = 0; cyc(1);
        chk("R5 free run code", st_code, 1);
        chk("R5 free run sel", sel_src, 0);
        chk("R12 trk low", tracking, 0);

        // R8: unconfigured secondary never used
        pri_en = 1; sec_en = 1; cyc(1);
        sec_cfg = 0; pri_en = 0; cyc(1);
        chk("R8 no secondary when unconfigured", sel_src, 0);
        chk("R8 free code", st_code, 1);
        sec_cfg = 1; cyc(1);
        chk("R8 secondary once configured", sel_src, 2);
        chk("R12 trk high", tracking, 1);

        // R9 / R10: forced free run and command ranking
        pri_en = 1; cyc(1);
        chk("R3 primary again", sel_src, 1);
        cmd_frun = 1; cyc(1); cmd_frun = 0;
        chk("R9 forced code", st_code, 2);
        chk("R9 forced sel", sel_src, 0);
        pri_en = 0; cyc(3); pri_en = 1; cyc(3);
        chk("R9 forced persists", st_code, 2);
        cmd_frun = 1; cmd_pri = 1; cyc(1); cmd_frun = 0; cmd_pri = 0;
        chk("R10 free-run ranks over track", st_code, 2);
        cmd_sec = 1; cyc(1); cmd_sec = 0;
        chk("R10 secondary by command", sel_src, 2);
        chk("R11 pulse on command switch", sw_evt, 1);
        cyc(3);
        chk("R10 secondary preference kept", sel_src, 2);
        cmd_pri = 1; cyc(1); cmd_pri = 0;
        chk("R10 primary restored", sel_src, 1);

        // R1: disable
        ctl_en = 0; cyc(1);
        chk("R1 disabled code", st_code, 0);
        chk("R1 disabled sel", sel_src, 0);

        // R2 boundary: zero hold
        hold_ticks = 0; ctl_en = 1; cyc(1);
        chk("R2 zero hold first edge", st_code, 0);
        cyc(1);
        chk("R2 zero hold leaves", sel_src, 1);

        // random phase against the model
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            chk("R4 sel vs model", sel_src, exp_sel(m_st));
            chk("R9 code vs model", st_code, exp_code(m_st));
            chk("R11 evt vs model", sw_evt, int'(exp_sel(m_st) != m_selq));
            chk("R12 trk vs model", tracking, int'(exp_sel(m_st) != 0));
            cmd_pri  = ($urandom % 40) == 0;
            cmd_sec  = ($urandom % 40) == 0;
            cmd_frun = ($urandom % 60) == 0;
            if (($urandom % 30) == 0) pri_alm = ~pri_alm;
            if (($urandom % 30) == 0) sec_alm = ~sec_alm;
            if (($urandom % 80) == 0) pri_en  = ~pri_en;
            if (($urandom % 80) == 0) sec_en  = ~sec_en;
            if (($urandom % 150) == 0) sec_cfg = ~sec_cfg;
            if (($urandom % 200) == 0) pri_cfg = ~pri_cfg;
            if (($urandom % 100) == 0) dbc_ticks = DW'($urandom % 4);
            if (($urandom % 400) == 0) begin
                ctl_en = ~ctl_en;
                hold_ticks = HW'($urandom % 5);
            end
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule